// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the sending half of an I2C bus master. It takes one byte at a time from the CPU side and shifts it onto the data line, most significant bit first. The byte may be a data byte, or a 7-bit target address with the read/write flag in bit 0. The block generates the bus clock from an internal bit-period counter. A programmable reload value sets the length of each clock half.

After eight data clocks the master lets go of the data line. It then reads the target's acknowledge during a ninth clock. When that clock ends, the block raises an interrupt flag and stops its counter. It holds the clock line low and leaves the data line released until the CPU writes the next byte. Start, stop and repeated-start conditions, arbitration, clock stretching and target mode are handled elsewhere.

Both bus lines are open-drain. An output enable of 1 pulls the line low, and a sense input returns the level on the wire.

The byte input is a valid/ready port. `tx_ready` is high only while no byte is in flight. This port does not apply back-pressure in the usual sense. A `tx_valid` presented while `tx_ready` is low is not held or queued. It is dropped at once and recorded as a write collision. The status pins are plain levels.

Top module: `i2c_byte_tx`

## Requirements
- R1: During reset and the first cycle after it, the outputs are as follows. `scl_oe`=1 (clock held low), `sda_oe`=0 (data released), `tx_ready`=1, and `buf_full`, `wcol`, `ack_stat` and `irq` are all 0.
- R2: A write is accepted when `tx_valid` and `tx_ready` are both high at a clock edge. On that edge the byte is captured, `buf_full` goes to 1 and `tx_ready` goes to 0.
- R3: The bits go out MSB first, one per SCL pulse, over the first eight pulses. A 1 bit releases SDA (`sda_oe`=0), and a 0 bit pulls SDA low (`sda_oe`=1).
- R4: Every SCL low half and every SCL high half lasts E+1 clocks, where E = max(`period_reload`, 1). A byte uses exactly nine SCL pulses, and the whole transfer lasts 18·(E+1) clocks from the accepting edge.
- R5: `buf_full` clears on the falling SCL edge that ends the eighth pulse, 16·(E+1) clocks after acceptance. SDA is released one clock later.
- R6: At the falling SCL edge that ends the ninth pulse, `ack_stat` takes the level of `sda_i`: 0 means ACK and 1 means NACK.
- R7: On that same edge, `irq` is set and `tx_ready` returns to 1. From then until the next accepted write, SCL stays low, SDA stays released and no clock pulses occur.
- R8: A one-clock pulse of `irq_clr` clears `irq` while no byte is in flight.
- R9: If `tx_valid` is high while `tx_ready` is low, `wcol` is set on that edge. The byte in flight is sent unchanged.
- R10: `wcol` stays set until a `wcol_clr` pulse. If a collision and a clear occur in the same cycle, the set wins.
- R11: `sda_oe` changes only on an edge where `scl_oe` was already 1 in the previous cycle and is still 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_reload | input | PER_W | Half-period reload value E (0 is treated as 1) |
| tx_valid | input | 1 | Byte write request |
| tx_data | input | DATA_W | Byte to send, MSB first |
| tx_ready | output | 1 | High when a write will be accepted |
| wcol_clr | input | 1 | Clears the write-collision flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| buf_full | output | 1 | A byte is held and its data bits are not all out yet |
| wcol | output | 1 | Sticky write-collision flag |
| ack_stat | output | 1 | Last acknowledge level: 0 = ACK, 1 = NACK |
| irq | output | 1 | Byte complete |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_i | input | 1 | SCL wire level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | SDA wire level |

## Verification
All timing is counted from the accepting edge k=0, with a half-period of H = E+1 clocks. The outputs are due as follows:

- `buf_full` and the loss of `tx_ready` appear at k=0.
- SCL rises at k=(2i+1)·H and falls at k=(2i+2)·H.
- `buf_full` drops at k=16H and SDA is released at k=16H+1.
- `irq`, `ack_stat` and the return of `tx_ready` all appear at k=18H.
- A collision is visible one clock after the refused write.

The bench samples on the falling clock edge. For each accepted byte it steps a cycle counter k and compares each flag at the cycle just before and the cycle of its due edge, so a result that is one clock early or late is caught. A monitor measures every SCL half, captures a data bit on each rising SCL, and counts SDA enable changes that happen outside a held-low clock.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_t;
endpackage

// File: rtl/i2c_tx_period.sv
module i2c_tx_period #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PER_W-1:0] reload,
  output logic             tick
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] eff;

  // A half period shorter than two clocks would let SDA move with SCL high.
  assign eff  = (reload == '0) ? PER_W'(1) : reload;
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= eff;
    else if (tick)    cnt <= eff;
    else if (run)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_tx_seq.sv
module i2c_tx_seq
  import i2c_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] byte_q,
  input  logic              tick,
  output logic              busy,
  output logic              scl_low,
  output logic              sda_low,
  output logic              data_end,
  output logic              ack_end
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  scl_phase_t       phase;
  logic [IDX_W-1:0] idx;
  logic             fall_d;
  logic             last_bit;
  logic [SEL_W-1:0] sel;
  logic             falling;

  assign last_bit = (idx == IDX_W'(DATA_W));
  assign sel      = SEL_W'(DATA_W - 1) - SEL_W'(idx);
  assign falling  = busy && tick && (phase == PH_HIGH);
  assign data_end = falling && (idx == IDX_W'(DATA_W - 1));
  assign ack_end  = falling && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= PH_LOW;
      idx     <= '0;
      fall_d  <= 1'b0;
      scl_low <= 1'b1;
      sda_low <= 1'b0;
    end else begin
      fall_d <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        phase   <= PH_LOW;
        idx     <= '0;
        scl_low <= 1'b1;
        sda_low <= ~byte_q[DATA_W-1];
      end else if (busy && tick) begin
        if (phase == PH_LOW) begin
          phase   <= PH_HIGH;
          scl_low <= 1'b0;
        end else begin
          phase   <= PH_LOW;
          scl_low <= 1'b1;
          if (last_bit) busy <= 1'b0;
          else begin
            idx    <= idx + 1'b1;
            fall_d <= 1'b1;
          end
        end
      end
      // SDA moves one clock after SCL has gone low.
      if (fall_d && !start)
        sda_low <= last_bit ? 1'b0 : ~byte_q[sel];
    end
  end
endmodule

// File: rtl/i2c_tx_status.sv
module i2c_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic refused,
  input  logic data_end,
  input  logic ack_end,
  input  logic sda_level,
  input  logic wcol_clr,
  input  logic irq_clr,
  output logic buf_full,
  output logic wcol,
  output logic ack_stat,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      wcol     <= 1'b0;
      ack_stat <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (start)         buf_full <= 1'b1;
      else if (data_end) buf_full <= 1'b0;
      if (refused)       wcol <= 1'b1;
      else if (wcol_clr) wcol <= 1'b0;
      if (ack_end)       ack_stat <= sda_level;
      if (ack_end)       irq <= 1'b1;
      else if (irq_clr)  irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
  parameter int DATA_W = 8,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  period_reload,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              wcol_clr,
  input  logic              irq_clr,
  output logic              buf_full,
  output logic              wcol,
  output logic              ack_stat,
  output logic              irq,
  output logic              scl_oe,
  input  logic              scl_i,
  output logic              sda_oe,
  input  logic              sda_i
);
  logic              busy, tick, start, refused, data_end, ack_end;
  logic [DATA_W-1:0] byte_q;
  logic              scl_seen;

  assign tx_ready = !busy;
  assign start    = tx_valid && !busy;
  assign refused  = tx_valid && busy;
  assign scl_seen = scl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     byte_q <= '0;
    else if (start) byte_q <= tx_data;
  end

  i2c_tx_period #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(busy),
    .reload(period_reload), .tick(tick)
  );

  i2c_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_q(start ? tx_data : byte_q),
    .tick(tick), .busy(busy), .scl_low(scl_oe), .sda_low(sda_oe),
    .data_end(data_end), .ack_end(ack_end)
  );

  i2c_tx_status u_status (
    .clk(clk), .rst_n(rst_n), .start(start), .refused(refused),
    .data_end(data_end), .ack_end(ack_end), .sda_level(sda_i),
    .wcol_clr(wcol_clr), .irq_clr(irq_clr), .buf_full(buf_full),
    .wcol(wcol), .ack_stat(ack_stat), .irq(irq)
  );

  logic unused_ok;
  assign unused_ok = scl_seen;
endmodule

// File: rtl/i2c_byte_tx_chk.sv
module i2c_byte_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic wcol_clr,
  input logic irq_clr,
  input logic buf_full,
  input logic wcol,
  input logic irq,
  input logic scl_oe,
  input logic sda_oe
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (buf_full && !tx_ready));

  assert_idle_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (scl_oe && !sda_oe));

  assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && tx_ready) |=> !irq);

  assert_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> wcol);

  assert_wcol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !wcol_clr) |=> wcol);

  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (scl_oe && $past(scl_oe)));
endmodule

bind i2c_byte_tx i2c_byte_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .wcol_clr(wcol_clr), .irq_clr(irq_clr), .buf_full(buf_full), .wcol(wcol),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_tx_tb_top.sv
module i2c_byte_tx_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period_reload = 8'd2;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       wcol_clr = 1'b0, irq_clr = 1'b0;
  logic       tx_ready, buf_full, wcol, ack_stat, irq, scl_oe, sda_oe;
  logic       scl_i, sda_i;

  int  nchk = 0, nfail = 0;
  int  exp_half = 3;
  int  rises = 0, falls = 0, hw = 0, lw = 0, sda_viol = 0;
  logic [7:0] cap = 8'h00;
  bit  ack_low = 1'b0;
  logic prev_scl = 1'b1, prev_sda = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign scl_i = !scl_oe;
  assign sda_i = !(sda_oe || (ack_low && falls >= 8));

  i2c_byte_tx dut_i (
    .clk(clk), .rst_n(rst_n), .period_reload(period_reload), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .wcol_clr(wcol_clr), .irq_clr(irq_clr),
    .buf_full(buf_full), .wcol(wcol), .ack_stat(ack_stat), .irq(irq),
    .scl_oe(scl_oe), .scl_i(scl_i), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int half_of(input int rl);
    return ((rl == 0) ? 1 : rl) + 1;
  endfunction

  // Bus monitor: SCL half widths, bit capture, SDA-while-high detection
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != prev_sda && !(scl_oe && prev_scl)) sda_viol++;
      if (prev_scl && !scl_oe) begin
        if (rises > 0) chk(lw == exp_half, "R4 low half", lw, exp_half);
        if (rises < 8) cap = {cap[6:0], sda_i};
        rises++;
        lw = 0;
      end else if (!prev_scl && scl_oe) begin
        chk(hw == exp_half, "R4 high half", hw, exp_half);
        falls++;
        hw = 0;
      end
      if (scl_oe) lw++; else hw++;
      prev_scl = scl_oe;
      prev_sda = sda_oe;
    end
  end

  task automatic send(input logic [7:0] d, input int rl, input bit nack, input bit collide);
    int h;
    h = half_of(rl);
    period_reload = 8'(rl);
    exp_half = h;
    ack_low = !nack;
    rises = 0; falls = 0; cap = 8'h00;
    chk(tx_ready, "R7 ready before write", int'(tx_ready), 1);
    tx_data = d; tx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0; tx_data = ~d;
    chk(buf_full && !tx_ready, "R2 accept", {buf_full, tx_ready}, 2);
    for (int k = 1; k <= 18 * h; k++) begin
      @(negedge clk);
      if (collide && k == 2) tx_valid = 1'b1;
      if (collide && k == 3) begin
        tx_valid = 1'b0;
        chk(wcol, "R9 collision flagged", int'(wcol), 1);
      end
      if (k == 16 * h - 1) chk(buf_full, "R5 full before 8th fall", int'(buf_full), 1);
      if (k == 16 * h)     chk(!buf_full, "R5 clear at 8th fall", int'(buf_full), 0);
      if (k == 16 * h + 1) chk(!sda_oe, "R5 SDA released", int'(sda_oe), 0);
      if (k == 18 * h - 1) chk(!irq && !tx_ready, "R7 not done early", {irq, tx_ready}, 0);
      if (k == 18 * h) begin
        chk(irq && tx_ready, "R7 irq and ready", {irq, tx_ready}, 3);
        chk(ack_stat == nack, "R6 ack status", int'(ack_stat), int'(nack));
      end
    end
    chk(cap == d, "R3 R9 byte on wire", int'(cap), int'(d));
    repeat (4) @(negedge clk);
    chk(rises == 9 && scl_oe && !sda_oe, "R7 parked, R4 nine pulses", rises, 9);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(!irq, "R8 irq cleared", int'(irq), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(scl_oe && !sda_oe && tx_ready && !buf_full && !wcol && !ack_stat && !irq,
        "R1 reset state", {scl_oe, sda_oe, tx_ready, buf_full, wcol, ack_stat, irq}, 7'b1010000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe && !sda_oe && tx_ready && !irq, "R1 after reset", {scl_oe, sda_oe, tx_ready, irq}, 4'b1010);
    send(8'hA5, 2, 1'b0, 1'b0);
    send(8'h00, 0, 1'b1, 1'b0);
    chk(!wcol, "R10 no spurious collision", int'(wcol), 0);
    send(8'hFF, 3, 1'b0, 1'b1);
    chk(wcol, "R10 wcol sticky", int'(wcol), 1);
    send(8'h81, 1, 1'b1, 1'b0);
    chk(wcol, "R10 wcol still sticky", int'(wcol), 1);
    wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    chk(!wcol, "R10 wcol cleared", int'(wcol), 0);
    for (int i = 0; i < 16; i++) begin
      send(8'($urandom), int'($urandom % 6), 1'($urandom), 1'b0);
    end
    chk(sda_viol == 0, "R11 SDA moved with SCL high", sda_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule